// File: doc/BRIEF.md
# Last Branch Record Ring Buffer

This block keeps a short history of control transfers: taken branches, interrupts and exceptions. Each accepted event stores one record of two linear addresses. The "from" address is where control left. The "to" address is where control went. Records go into a circular buffer whose depth is a parameter. A top-of-stack pointer always names the newest record, so software can walk backwards from it through older history.

Each cycle the event source presents a two-bit kind code and three candidate addresses. These are the address of the current instruction, the address of the next sequential instruction, and the destination address. The kind code decides which candidate becomes "from". Software reads any record and the pointer through a combinational read port that has no write path.

Top module: `branch_trace_ring`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the pointer is set to DEPTH-1 and every record's from and to addresses are cleared to zero.
- R2: On every accepted event, the pointer is first incremented by one, and the new record is written into the entry that the incremented pointer names. The pointer therefore always names the newest record.
- R3: When an event is accepted while the pointer equals DEPTH-1, the pointer wraps to 0 and the record is stored in entry 0, overwriting the oldest record.
- R4: For kind 2'b01 (taken branch), the stored "from" is `curAddr` and the stored "to" is `dstAddr`.
- R5: For kind 2'b10 (interrupt), the stored "from" is `nextAddr`, which is the saved return address, and the stored "to" is `dstAddr`.
- R6: For kind 2'b11 (exception), the stored "from" is `curAddr`, which is the faulting instruction, and the stored "to" is `dstAddr`.
- R7: Kind 2'b00 means no event. It leaves the pointer and every record unchanged.
- R8: `rdFrom` and `rdTo` show entry `rdIdx` combinationally. If `rdIdx` names the entry being written in the same cycle, the read shows the old contents until the clock edge.
- R9: At most one record is written per clock. An event changes no entry other than the one the incremented pointer names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evKind | input | 2 | Event kind: 00 none, 01 branch, 10 interrupt, 11 exception |
| curAddr | input | ADDR_W | Address of the current instruction |
| nextAddr | input | ADDR_W | Address of the next sequential instruction |
| dstAddr | input | ADDR_W | Destination address of the transfer |
| rdIdx | input | $clog2(DEPTH) | Entry selected for reading |
| rdFrom | output | ADDR_W | "From" address of the selected entry |
| rdTo | output | ADDR_W | "To" address of the selected entry |
| topPtr | output | $clog2(DEPTH) | Index of the newest record |

## Verification
The bench builds the block with DEPTH=4 and ADDR_W=32. The small depth means a run of twelve events wraps the pointer several times. Records are overwritten after only four captures, so the bench sees both wrap-around and the eviction of the oldest entry. The narrower address keeps the vectors readable and still gives each of the three candidate addresses a distinct value, so a wrong "from" choice shows up at once.

// File: rtl/btr_pkg.sv
package btr_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_BRANCH = 2'b01,
    EV_INTR   = 2'b10,
    EV_EXCP   = 2'b11
  } evKind_e;

  typedef enum logic {
    SRC_CUR  = 1'b0,
    SRC_NEXT = 1'b1
  } fromSrc_e;

  typedef struct packed {
    logic     capture;
    fromSrc_e fromSrc;
  } stbCtl_t;
endpackage

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
  import btr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  evKind_e          evKind,
  output stbCtl_t          stb,
  output logic [PTR_W-1:0] wrSlot,
  output logic [PTR_W-1:0] topPtr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptrQ;

  always_comb begin
    stb.capture = (evKind != EV_NONE);
    stb.fromSrc = (evKind == EV_INTR) ? SRC_NEXT : SRC_CUR;
    wrSlot      = (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)              ptrQ <= LAST;
    else if (stb.capture) ptrQ <= wrSlot;
  end

  assign topPtr = ptrQ;

  // R2: pre-increment by one on capture
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (evKind != EV_NONE && topPtr != LAST) |=> topPtr == $past(topPtr) + 1'b1);
  // R3: wrap from the top index to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (evKind != EV_NONE && topPtr == LAST) |=> topPtr == '0);
  // R7: no event holds the pointer
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (evKind == EV_NONE) |=> $stable(topPtr));
endmodule

// File: rtl/trace_ring_store.sv
module trace_ring_store
  import btr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  stbCtl_t           stb,
  input  logic [PTR_W-1:0]  wrSlot,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] rdFrom,
  output logic [ADDR_W-1:0] rdTo
);
  logic [ADDR_W-1:0] fromMem [DEPTH];
  logic [ADDR_W-1:0] toMem   [DEPTH];
  logic [ADDR_W-1:0] fromVal;

  assign fromVal = (stb.fromSrc == SRC_NEXT) ? nextAddr : curAddr;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        fromMem[e] <= '0;
        toMem[e]   <= '0;
      end else if (stb.capture && wrSlot == PTR_W'(e)) begin
        fromMem[e] <= fromVal;
        toMem[e]   <= dstAddr;
      end
    end
  end

  assign rdFrom = fromMem[rdIdx];
  assign rdTo   = toMem[rdIdx];

  // R5: interrupt records the return address as "from"
  a_r5_intr_from: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && stb.fromSrc == SRC_NEXT) |=> fromMem[$past(wrSlot)] == $past(nextAddr));
  // R4: every record takes the destination as "to"
  a_r4_to_dst: assert property (@(posedge clk) disable iff (rst)
    stb.capture |=> toMem[$past(wrSlot)] == $past(dstAddr));
endmodule

// File: rtl/branch_trace_ring.sv
module branch_trace_ring
  import btr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        evKind,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] rdFrom,
  output logic [ADDR_W-1:0] rdTo,
  output logic [PTR_W-1:0]  topPtr
);
  stbCtl_t          stb;
  logic [PTR_W-1:0] wrSlot;

  trace_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .evKind(evKind_e'(evKind)),
    .stb(stb), .wrSlot(wrSlot), .topPtr(topPtr)
  );

  trace_ring_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .stb(stb), .wrSlot(wrSlot),
    .curAddr(curAddr), .nextAddr(nextAddr), .dstAddr(dstAddr),
    .rdIdx(rdIdx), .rdFrom(rdFrom), .rdTo(rdTo)
  );
endmodule

// File: tb/test_branch_trace_ring.sv
module test_branch_trace_ring;
  localparam int DEPTH = 4;
  localparam int AW    = 32;
  localparam int PW    = 2;
  localparam int NVEC  = 12;
  // vector table: event kind per step (00 none, 01 branch, 10 interrupt, 11 exception)
  localparam logic [1:0] VK [NVEC] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b01, 2'b00,
                                       2'b10, 2'b11, 2'b10, 2'b01, 2'b00, 2'b11};

  logic clk = 0, rst = 1;
  logic [1:0]    evKind = 0;
  logic [AW-1:0] curAddr = 0, nextAddr = 0, dstAddr = 0;
  logic [PW-1:0] rdIdx = 0;
  logic [AW-1:0] rdFrom, rdTo;
  logic [PW-1:0] topPtr;

  int nChk = 0, nFail = 0;
  logic [AW-1:0] mFrom [DEPTH];
  logic [AW-1:0] mTo   [DEPTH];
  int mPtr;

  always #4 clk = ~clk;

  branch_trace_ring #(.DEPTH(DEPTH), .ADDR_W(AW)) i_branch_trace_ring (
    .clk(clk), .rst(rst), .evKind(evKind), .curAddr(curAddr), .nextAddr(nextAddr),
    .dstAddr(dstAddr), .rdIdx(rdIdx), .rdFrom(rdFrom), .rdTo(rdTo), .topPtr(topPtr)
  );

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    for (int e = 0; e < DEPTH; e++) begin
      rdIdx = PW'(e);
      #1;
      chk(req, rdFrom, mFrom[e]);
      chk(req, rdTo, mTo[e]);
    end
  endtask

  task automatic modelReset();
    mPtr = DEPTH - 1;
    for (int e = 0; e < DEPTH; e++) begin
      mFrom[e] = '0;
      mTo[e]   = '0;
    end
  endtask

  task automatic setAddrs(int i);
    curAddr  = 32'h0040_0000 + 32'(i) * 32'h10;
    nextAddr = curAddr + 32'h4;
    dstAddr  = 32'h00A0_0000 + 32'(i) * 32'h100;
  endtask

  function automatic string kindReq(logic [1:0] k);
    case (k)
      2'b01:   return "R4";
      2'b10:   return "R5";
      2'b11:   return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 ptr", AW'(topPtr), AW'(DEPTH - 1));
    checkAll("R1 entries");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic wrapped;
      wrapped = 0;
      @(negedge clk);
      evKind = VK[i];
      setAddrs(i);
      if (VK[i] != 2'b00) begin
        wrapped = (mPtr == DEPTH - 1);
        mPtr = (mPtr + 1) % DEPTH;
        mFrom[mPtr] = (VK[i] == 2'b10) ? nextAddr : curAddr;
        mTo[mPtr]   = dstAddr;
      end
      @(negedge clk);
      evKind = 2'b00;
      if (VK[i] == 2'b00) begin
        chk("R7 ptr hold", AW'(topPtr), AW'(mPtr));
        checkAll("R7 entries unchanged");
      end else begin
        chk(wrapped ? "R3 wrap ptr" : "R2 ptr step", AW'(topPtr), AW'(mPtr));
        rdIdx = PW'(mPtr);
        #1;
        chk({kindReq(VK[i]), " from"}, rdFrom, mFrom[mPtr]);
        chk({kindReq(VK[i]), " to"}, rdTo, mTo[mPtr]);
        checkAll("R9 other entries");
      end
    end

    // R8: read of the slot being written returns old contents before the edge
    @(negedge clk);
    rdIdx = PW'((mPtr + 1) % DEPTH);
    evKind = 2'b01;
    setAddrs(40);
    #1;
    chk("R8 pre-edge from", rdFrom, mFrom[(mPtr + 1) % DEPTH]);
    chk("R8 pre-edge to", rdTo, mTo[(mPtr + 1) % DEPTH]);
    mPtr = (mPtr + 1) % DEPTH;
    mFrom[mPtr] = curAddr;
    mTo[mPtr]   = dstAddr;
    @(negedge clk);
    evKind = 2'b00;
    #1;
    chk("R8 post-edge from", rdFrom, mFrom[mPtr]);
    chk("R8 post-edge to", rdTo, mTo[mPtr]);

    // R1: reset in the middle of a run, with an event pending
    @(negedge clk);
    rst = 1;
    evKind = 2'b11;
    @(negedge clk);
    rst = 0;
    evKind = 2'b00;
    modelReset();
    chk("R1 mid-run ptr", AW'(topPtr), AW'(DEPTH - 1));
    checkAll("R1 mid-run entries");

    // R3: first capture after reset lands in entry 0
    @(negedge clk);
    evKind = 2'b10;
    setAddrs(77);
    @(negedge clk);
    evKind = 2'b00;
    mPtr = 0;
    mFrom[0] = nextAddr;
    mTo[0]   = dstAddr;
    chk("R3 first slot", AW'(topPtr), 0);
    checkAll("R5 first record");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule